// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a small programmable logic array. It takes 12 logic inputs and forms 8 product terms, and every one of its 4 outputs can use any of those terms. For each term, the configuration gives each input one of three roles: it is used true, it is used complemented, or it is left out. Each output is the OR of a masked subset of the 8 terms. The result then passes through a macrocell. The macrocell can invert the polarity and can either pass the value straight through or capture it in a flip-flop, so the array can hold state bits and state machines as well as plain equations.

Configuration is loaded through an addressed write port that is 8 bits wide and is held static afterwards. A carry input can be folded into product term 0. A carry output exposes the sum that feeds output 3. Together these let neighbouring arrays be chained, for example to ripple a counter across several arrays.

Top module: `sop_logic_array`

## Requirements
- R1: Term t is the AND of its enabled literals. Input i is used true when bit i of the term's true mask is set, and complemented when bit i of its complement mask is set. Each mask has 12 bits. Addresses 4t+0 and 4t+1 hold the true mask bits [7:0] and [11:8]. Addresses 4t+2 and 4t+3 hold the complement mask bits [7:0] and [11:8]. The upper register of each pair takes its value from data bits [3:0].
- R2: When both the true bit and the complement bit of the same input are set in a term, that term is 0 for every input value.
- R3: A term with no enabled literals evaluates to 0.
- R4: Output o is the OR of the terms selected by the 8-bit mask at address 32+o, where bit t selects term t. An all-zero mask gives a sum of 0.
- R5: Bit 4+o of the macrocell register at address 36 inverts output o.
- R6: When bit o of address 36 is clear, output o is combinational: it follows the inputs with no clock edge.
- R7: When bit o of address 36 is set, output o takes the inverted-or-not sum at a rising clock edge and holds it until the next edge.
- R8: When bit 0 of address 37 is set, carry_i is ANDed into term 0. When that bit is clear, carry_i has no effect.
- R9: carry_o equals the OR-plane sum for output 3, taken before polarity inversion and before the register.
- R10: Writes to unmapped addresses 38 to 63 change no configuration.
- R11: After reset, all configuration and all macrocell flip-flops are 0, so out_o and carry_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 6 | Configuration register address |
| cfg_wdata_i | input | 8 | Configuration write data |
| in_i | input | 12 | Logic inputs from the routing bus |
| carry_i | input | 1 | Carry from the neighbouring array |
| out_o | output | 4 | Macrocell outputs |
| carry_o | output | 1 | Carry to the neighbouring array |

## Verification
A configuration write takes effect at the rising edge where the strobe is sampled. The bench therefore drives each write at a falling edge and evaluates only after the following rising edge. Combinational outputs and carry_o are due in the same cycle as the input change, so the bench samples them one time step after driving in_i, away from any edge. A registered output is due one rising edge after its inputs settle. The bench first checks that the output has not moved before that edge, then checks the new value just after it. Expected values come from a model of the configured equations that the bench keeps itself.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int IN_W   = 12;
  localparam int PT_N   = 8;
  localparam int OUT_N  = 4;
  localparam int CFG_AW = 6;
  localparam int CFG_DW = 8;
  localparam int HI_W   = IN_W - 8;
  localparam int PT_AW  = $clog2(PT_N);
  localparam int OUT_AW = $clog2(OUT_N);

  typedef logic [PT_N-1:0][IN_W-1:0] lit_mask_t;
  typedef logic [OUT_N-1:0][PT_N-1:0] or_mask_t;
endpackage

// File: rtl/sop_cfg_regs.sv
module sop_cfg_regs
  import sop_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [CFG_DW-1:0] wdata_i,
  output lit_mask_t         tru_o,
  output lit_mask_t         cmp_o,
  output or_mask_t          orm_o,
  output logic [OUT_N-1:0]  rsel_o,
  output logic [OUT_N-1:0]  inv_o,
  output logic              cen_o
);
  localparam logic [CFG_AW-1:0] OR_BASE = CFG_AW'(PT_N * 4);
  localparam logic [CFG_AW-1:0] MC_ADDR = CFG_AW'(PT_N * 4 + OUT_N);
  localparam logic [CFG_AW-1:0] CE_ADDR = CFG_AW'(PT_N * 4 + OUT_N + 1);
  localparam logic [CFG_AW-1:0] MAP_END = CFG_AW'(PT_N * 4 + OUT_N + 2);

  logic [PT_AW-1:0]  pt_sel;
  logic [1:0]        sub_sel;
  logic [OUT_AW-1:0] out_sel;

  assign pt_sel  = addr_i[PT_AW+1:2];
  assign sub_sel = addr_i[1:0];
  assign out_sel = addr_i[OUT_AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tru_o  <= '0;
      cmp_o  <= '0;
      orm_o  <= '0;
      rsel_o <= '0;
      inv_o  <= '0;
      cen_o  <= 1'b0;
    end else if (we_i) begin
      if (addr_i < OR_BASE) begin
        unique case (sub_sel)
          2'd0: tru_o[pt_sel][7:0]      <= wdata_i;
          2'd1: tru_o[pt_sel][IN_W-1:8] <= wdata_i[HI_W-1:0];
          2'd2: cmp_o[pt_sel][7:0]      <= wdata_i;
          default: cmp_o[pt_sel][IN_W-1:8] <= wdata_i[HI_W-1:0];
        endcase
      end else if (addr_i < MC_ADDR) begin
        orm_o[out_sel] <= wdata_i[PT_N-1:0];
      end else if (addr_i == MC_ADDR) begin
        rsel_o <= wdata_i[OUT_N-1:0];
        inv_o  <= wdata_i[2*OUT_N-1:OUT_N];
      end else if (addr_i == CE_ADDR) begin
        cen_o  <= wdata_i[0];
      end
      // addresses at or above MAP_END are dropped
    end
  end

  p_unmapped_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i >= MAP_END) |=> ($stable(tru_o) && $stable(cmp_o) && $stable(orm_o)
                                     && $stable(rsel_o) && $stable(inv_o) && $stable(cen_o)));
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane
  import sop_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IN_W-1:0] in_i,
  input  lit_mask_t       tru_i,
  input  lit_mask_t       cmp_i,
  input  logic            cen_i,
  input  logic            carry_i,
  output logic [PT_N-1:0] pt_o
);
  logic [PT_N-1:0] raw;

  for (genvar t = 0; t < PT_N; t++) begin : g_term
    logic used;
    logic match;
    assign used  = |(tru_i[t] | cmp_i[t]);
    assign match = &(~tru_i[t] | in_i) & &(~cmp_i[t] | ~in_i);
    assign raw[t] = used & match;

    p_conflict_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(tru_i[t] & cmp_i[t])) |-> !pt_o[t]);
    p_empty_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tru_i[t] == '0 && cmp_i[t] == '0) |-> !pt_o[t]);
  end

  // carry folds into term 0 only
  assign pt_o[0] = raw[0] & (carry_i | ~cen_i);
  assign pt_o[PT_N-1:1] = raw[PT_N-1:1];

  p_carry_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cen_i && !carry_i) |-> !pt_o[0]);
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane
  import sop_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PT_N-1:0]  pt_i,
  input  or_mask_t         orm_i,
  output logic [OUT_N-1:0] sum_o
);
  for (genvar o = 0; o < OUT_N; o++) begin : g_sum
    assign sum_o[o] = |(pt_i & orm_i[o]);

    p_zero_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (orm_i[o] == '0) |-> !sum_o[o]);
  end
endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sum_i,
  input  logic inv_i,
  input  logic rsel_i,
  output logic out_o
);
  logic d;
  logic q_q;

  assign d = sum_i ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= d;
  end

  assign out_o = rsel_i ? q_q : d;

  p_reg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsel_i && $stable(rsel_i)) |-> $stable(out_o) or $changed(q_q));
endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
  import sop_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  input  logic [IN_W-1:0]   in_i,
  input  logic              carry_i,
  output logic [OUT_N-1:0]  out_o,
  output logic              carry_o
);
  lit_mask_t        tru, cmp;
  or_mask_t         orm;
  logic [OUT_N-1:0] rsel, inv, sum;
  logic             cen;
  logic [PT_N-1:0]  pt;

  sop_cfg_regs u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .tru_o(tru), .cmp_o(cmp), .orm_o(orm),
    .rsel_o(rsel), .inv_o(inv), .cen_o(cen)
  );

  sop_and_plane u_and (
    .clk_i, .rst_ni, .in_i,
    .tru_i(tru), .cmp_i(cmp), .cen_i(cen), .carry_i,
    .pt_o(pt)
  );

  sop_or_plane u_or (
    .clk_i, .rst_ni, .pt_i(pt), .orm_i(orm), .sum_o(sum)
  );

  for (genvar o = 0; o < OUT_N; o++) begin : g_mc
    sop_macrocell u_mc (
      .clk_i, .rst_ni,
      .sum_i(sum[o]), .inv_i(inv[o]), .rsel_i(rsel[o]),
      .out_o(out_o[o])
    );
  end

  assign carry_o = sum[OUT_N-1];

  p_zero_mask_carry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (orm[OUT_N-1] == '0) |-> !carry_o);
endmodule

// File: tb/sop_logic_array_test.sv
module sop_logic_array_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [5:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [11:0] in_i = '0;
  logic        carry_i = 1'b0;
  logic [3:0]  out_o;
  logic        carry_o;

  int checks = 0;
  int fails  = 0;

  logic [11:0] m_tru [8];
  logic [11:0] m_cmp [8];
  logic [7:0]  m_orm [4];
  logic [3:0]  m_rsel, m_inv;
  logic        m_cen;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sop_logic_array uut (.*);

  function automatic logic [3:0] model_sum(input logic [11:0] x, input logic c);
    logic [7:0] pt;
    logic [3:0] s;
    for (int t = 0; t < 8; t++)
      pt[t] = ((m_tru[t] | m_cmp[t]) != 0) && ((x & m_tru[t]) == m_tru[t])
              && ((~x & m_cmp[t]) == m_cmp[t]);
    if (m_cen && !c) pt[0] = 1'b0;
    for (int o = 0; o < 4; o++) s[o] = |(pt & m_orm[o]);
    return s;
  endfunction

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic set_term(input int t, input logic [11:0] tm, input logic [11:0] cm);
    wr(6'(4*t),   tm[7:0]);
    wr(6'(4*t+1), {4'h0, tm[11:8]});
    wr(6'(4*t+2), cm[7:0]);
    wr(6'(4*t+3), {4'h0, cm[11:8]});
    m_tru[t] = tm; m_cmp[t] = cm;
  endtask

  task automatic set_or(input int o, input logic [7:0] m);
    wr(6'(32+o), m); m_orm[o] = m;
  endtask

  task automatic set_mc(input logic [3:0] rs, input logic [3:0] iv);
    wr(6'd36, {iv, rs}); m_rsel = rs; m_inv = iv;
  endtask

  task automatic set_cen(input logic e);
    wr(6'd37, {7'd0, e}); m_cen = e;
  endtask

  // combinational check of all outputs and carry
  task automatic comb_chk(input string req, input logic [11:0] x, input logic c);
    logic [3:0] s;
    in_i = x; carry_i = c;
    #1;
    s = model_sum(x, c);
    chk(req, {carry_o, out_o}, {s[3], s ^ m_inv});
  endtask

  task automatic t_reset;
    in_i = 12'hA5C; carry_i = 1'b1; #1;
    chk("R11 reset", {carry_o, out_o}, 5'b0);
  endtask

  task automatic t_literals;
    set_term(0, 12'h001, 12'h002);  // in0 & ~in1
    set_or(0, 8'h01);
    comb_chk("R1 lit 01", 12'h001, 1'b0);
    comb_chk("R1 lit 11", 12'h003, 1'b0);
    comb_chk("R1 lit 00", 12'h000, 1'b0);
    comb_chk("R6 comb follow", 12'hFFD, 1'b0);
    chk("R1 in0&~in1", {1'b0, out_o}, 5'b00001);
  endtask

  task automatic t_conflict;
    set_term(1, 12'h804, 12'h004);
    set_or(1, 8'h02);
    for (int i = 0; i < 8; i++) begin
      comb_chk("R2 conflict", 12'(i * 613), 1'b0);
      chk("R2 out1 zero", {4'b0, out_o[1]}, 5'b0);
    end
  endtask

  task automatic t_empty;
    set_or(2, 8'h80);  // term 7 never programmed
    for (int i = 0; i < 6; i++) begin
      comb_chk("R3 empty", 12'(i * 977), 1'b0);
      chk("R3 out2 zero", {4'b0, out_o[2]}, 5'b0);
    end
  endtask

  task automatic t_invert;
    set_mc(4'h0, 4'h5);
    comb_chk("R5 invert", 12'h001, 1'b0);
    comb_chk("R5 invert", 12'h000, 1'b0);
    set_mc(4'h0, 4'h0);
  endtask

  task automatic t_random;
    for (int t = 0; t < 8; t++) set_term(t, 12'($urandom) & 12'($urandom), 12'($urandom) & 12'($urandom) & 12'($urandom));
    for (int o = 0; o < 4; o++) set_or(o, 8'($urandom));
    for (int i = 0; i < 200; i++) comb_chk("R4 random", 12'($urandom), 1'($urandom));
  endtask

  task automatic t_carry;
    set_term(0, 12'h010, 12'h000);
    set_or(3, 8'h01);
    set_mc(4'h0, 4'h8);
    set_cen(1'b0);
    comb_chk("R8 carry off c0", 12'h010, 1'b0);
    comb_chk("R9 carry_o", 12'h010, 1'b1);
    set_cen(1'b1);
    comb_chk("R8 carry on c0", 12'h010, 1'b0);
    comb_chk("R8 carry on c1", 12'h010, 1'b1);
    chk("R9 carry_o pre-invert", {carry_o, out_o[3], 3'b0}, {1'b1, 1'b0, 3'b0});
    set_mc(4'h0, 4'h0);
    set_cen(1'b0);
  endtask

  task automatic t_registered;
    logic [3:0] prev;
    logic [11:0] x;
    set_mc(4'hF, 4'h2);
    @(negedge clk_i);
    prev = model_sum(in_i, carry_i) ^ m_inv;
    for (int i = 0; i < 20; i++) begin
      x = 12'($urandom);
      @(negedge clk_i);
      in_i = x; #1;
      chk("R7 hold before edge", {1'b0, out_o}, {1'b0, prev});
      @(posedge clk_i); #1;
      prev = model_sum(x, carry_i) ^ m_inv;
      chk("R7 capture", {carry_o, out_o}, {model_sum(x, carry_i) >> 3 != 0, prev});
    end
    set_mc(4'h0, 4'h0);
  endtask

  task automatic t_unmapped;
    for (int a = 38; a < 64; a++) wr(6'(a), 8'hFF);
    for (int i = 0; i < 30; i++) comb_chk("R10 unmapped", 12'($urandom), 1'($urandom));
  endtask

  initial begin
    for (int t = 0; t < 8; t++) begin m_tru[t] = '0; m_cmp[t] = '0; end
    for (int o = 0; o < 4; o++) m_orm[o] = '0;
    m_rsel = '0; m_inv = '0; m_cen = 1'b0;
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_literals;
    t_conflict;
    t_empty;
    t_invert;
    t_carry;
    t_random;
    t_registered;
    t_unmapped;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule